// File: doc/BRIEF.md
# Flash Status Polling Controller

This controller sits on the host side of a parallel flash device and waits for an embedded program or erase operation to finish. A one-cycle start pulse arms it once the final write of the command sequence is complete, together with a flag that marks the operation as a sector erase and the address the status reads are sent to. From then on it issues back-to-back status reads on a simple request/acknowledge bus. It decides whether the device is still working by comparing the toggling status bit between consecutive reads.

A set error bit makes the controller take two confirming reads. If the device really failed, or if a configurable poll budget runs out, the controller writes the reset command to the device before it raises a failure pulse with a code. While a sector erase is running, the host may ask for one more sector to be added. The controller reads the window bit before the extra erase command and reads it again after it. It reports an append that was refused or that may not have been taken.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After an accepted start, the first status read only records bit 6 (TOG_BIT). Every later polling read compares bit 6 with the read before it. When the two are equal, done_o pulses in the cycle after the ack of that read.
- R2: On a polling read whose bit 6 differs from the previous read and whose bit 5 (ERR_BIT) is 1, the controller makes two more reads. If bit 6 differs between those two, the operation fails with the device-error code. If it is equal, done_o pulses instead.
- R3: fail_code_o uses the encoding 0 = none, 1 = device error, 2 = poll timeout. It is valid with fail_o and keeps its value until the next accepted start clears it to 0.
- R4: Every failure first issues one write of RESET_CMD (0xF0) to the operation address. fail_o pulses in the cycle after the ack of that write.
- R5: Status reads are counted from start, and the baseline read is included. If the MAX_POLLS-th read still differs from the one before it and bit 5 is 0, the controller takes the timeout failure path. An equal result on that read gives done_o.
- R6: An append request is taken only while a sector erase is in progress and no other append is pending. It is served after the current read. A read is made first. If bit 3 (WIN_BIT) is 0, ERASE_CMD (0x30) is written to the append address. If bit 3 is 1, append_rej_o pulses and nothing is written.
- R7: After the append write, bit 3 is read again. If it is 1, append_rej_o pulses. Polling then restarts with a new baseline read.
- R8: done_o, fail_o and append_rej_o are one-cycle pulses, and done_o and fail_o are never high together. With either of them high, bus_req_o is low and the controller is idle.
- R9: The bus runs one transaction at a time. bus_req_o, bus_we_o, bus_addr_o and bus_wdata_o hold their values until the cycle in which bus_ack_i is high, and read data is sampled in that cycle.
- R10: A start pulse during an operation has no effect. An append request during a program operation (sector-erase flag clear) has no effect.
- R11: After reset, bus_req_o, done_o, fail_o, append_rej_o and fail_code_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that arms polling |
| erase_i | input | 1 | Operation is a sector erase (sampled with start_i) |
| op_addr_i | input | AW | Address used for status reads and the reset write (sampled with start_i) |
| append_i | input | 1 | One-cycle request to add a sector erase |
| append_addr_i | input | AW | Sector address for the extra erase command |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Transaction address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with ack |
| bus_ack_i | input | 1 | Transaction complete |
| done_o | output | 1 | Operation completed pulse |
| fail_o | output | 1 | Operation failed pulse |
| fail_code_o | output | 2 | Failure reason |
| append_rej_o | output | 1 | Append refused or possibly not accepted pulse |

## Verification
done_o is due one cycle after the ack of the deciding read, either a polling read or the second confirming read. fail_o is due one cycle after the ack of the reset-command write, and append_rej_o one cycle after the ack of the window read that triggers it. The bench device model acknowledges after a random latency and returns a toggle bit that follows a programmed busy length, so the read count at which each pulse is due can be computed in advance. The bench samples all outputs on the falling edge, counts pulses and transactions there, and compares the counts to the computed read and write totals once the operation ends.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_BASE,
    ST_POLL,
    ST_CONF_A,
    ST_CONF_B,
    ST_AP_PRE,
    ST_AP_WR,
    ST_AP_POST,
    ST_RST_WR
  } fpc_state_e;

  localparam logic [1:0] FC_NONE    = 2'd0;
  localparam logic [1:0] FC_DEVICE  = 2'd1;
  localparam logic [1:0] FC_TIMEOUT = 2'd2;

endpackage

// File: rtl/fpc_bus_port.sv
module fpc_bus_port #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic          issue_we_i,
  input  logic [AW-1:0] issue_addr_i,
  input  logic [DW-1:0] issue_wdata_i,
  input  logic          ack_i,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);

  logic          req_q, req_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] wdata_q, wdata_d;
  logic          load_en;

  assign load_en = issue_i;

  always_comb begin
    req_d   = req_q;
    we_d    = we_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    if (issue_i) begin
      req_d   = 1'b1;
      we_d    = issue_we_i;
      addr_d  = issue_addr_i;
      wdata_d = issue_wdata_i;
    end else if (ack_i && req_q) begin
      req_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      we_q    <= we_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
    end
  end

  assign req_o   = req_q;
  assign we_o    = we_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;

endmodule

// File: rtl/fpc_toggle_track.sv
module fpc_toggle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic bit_i,
  output logic differ_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else if (load_i) begin
      prev_q <= bit_i;
    end
  end

  assign differ_o = bit_i ^ prev_q;

endmodule

// File: rtl/fpc_poll_cnt.sv
module fpc_poll_cnt #(
  parameter int MAX_POLLS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);

  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i | inc_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && cnt_q != CW'(MAX_POLLS)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q >= LAST_VAL);

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
  import fpc_pkg::*;
#(
  parameter int          AW         = 20,
  parameter int          DW         = 8,
  parameter int          MAX_POLLS  = 16,
  parameter int          TOG_BIT    = 6,
  parameter int          ERR_BIT    = 5,
  parameter int          WIN_BIT    = 3,
  parameter logic [7:0]  RESET_CMD  = 8'hF0,
  parameter logic [7:0]  ERASE_CMD  = 8'h30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic          append_i,
  input  logic [AW-1:0] append_addr_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ack_i,
  output logic          done_o,
  output logic          fail_o,
  output logic [1:0]    fail_code_o,
  output logic          append_rej_o
);

  localparam logic [DW-1:0] RST_WORD = DW'(RESET_CMD);
  localparam logic [DW-1:0] ERS_WORD = DW'(ERASE_CMD);

  fpc_state_e    state_q, state_d;
  logic          erase_q, erase_d;
  logic [AW-1:0] opad_q, opad_d;
  logic          pend_q, pend_d;
  logic [AW-1:0] pad_q, pad_d;
  logic [1:0]    code_q, code_d;
  logic          done_q, done_d;
  logic          fail_q, fail_d;
  logic          rej_q, rej_d;

  logic          issue, issue_we;
  logic [AW-1:0] issue_addr;
  logic [DW-1:0] issue_wdata;
  logic          tog_load, cnt_clr, cnt_inc;
  logic          differ, poll_last, ack;
  logic          tog_now, err_now, win_now;
  logic          pend_clr, op_busy;
  logic          opad_en, pad_en;

  fpc_bus_port #(.AW(AW), .DW(DW)) u_port (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_i       (issue),
    .issue_we_i    (issue_we),
    .issue_addr_i  (issue_addr),
    .issue_wdata_i (issue_wdata),
    .ack_i         (bus_ack_i),
    .req_o         (bus_req_o),
    .we_o          (bus_we_o),
    .addr_o        (bus_addr_o),
    .wdata_o       (bus_wdata_o)
  );

  fpc_toggle_track u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tog_load),
    .bit_i    (tog_now),
    .differ_o (differ)
  );

  fpc_poll_cnt #(.MAX_POLLS(MAX_POLLS)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .last_o (poll_last)
  );

  assign ack     = bus_ack_i & bus_req_o;
  assign tog_now = bus_rdata_i[TOG_BIT];
  assign err_now = bus_rdata_i[ERR_BIT];
  assign win_now = bus_rdata_i[WIN_BIT];
  assign op_busy = (state_q != ST_IDLE);

  // Next-state and control decode
  always_comb begin
    state_d     = state_q;
    erase_d     = erase_q;
    opad_d      = opad_q;
    code_d      = code_q;
    done_d      = 1'b0;
    fail_d      = 1'b0;
    rej_d       = 1'b0;
    issue       = 1'b0;
    issue_we    = 1'b0;
    issue_addr  = opad_q;
    issue_wdata = '0;
    tog_load    = 1'b0;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    pend_clr    = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        pend_clr = 1'b1;
        if (start_i) begin
          erase_d    = erase_i;
          opad_d     = op_addr_i;
          code_d     = FC_NONE;
          cnt_clr    = 1'b1;
          issue      = 1'b1;
          issue_addr = op_addr_i;
          state_d    = ST_BASE;
        end
      end

      ST_BASE: begin
        if (ack) begin
          tog_load = 1'b1;
          cnt_inc  = 1'b1;
          issue    = 1'b1;
          state_d  = (pend_q && erase_q) ? ST_AP_PRE : ST_POLL;
        end
      end

      ST_POLL: begin
        if (ack) begin
          tog_load = 1'b1;
          cnt_inc  = 1'b1;
          if (!differ) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (err_now) begin
            issue   = 1'b1;
            state_d = ST_CONF_A;
          end else if (poll_last) begin
            code_d      = FC_TIMEOUT;
            issue       = 1'b1;
            issue_we    = 1'b1;
            issue_wdata = RST_WORD;
            state_d     = ST_RST_WR;
          end else begin
            issue   = 1'b1;
            state_d = (pend_q && erase_q) ? ST_AP_PRE : ST_POLL;
          end
        end
      end

      ST_CONF_A: begin
        if (ack) begin
          tog_load = 1'b1;
          issue    = 1'b1;
          state_d  = ST_CONF_B;
        end
      end

      ST_CONF_B: begin
        if (ack) begin
          if (differ) begin
            code_d      = FC_DEVICE;
            issue       = 1'b1;
            issue_we    = 1'b1;
            issue_wdata = RST_WORD;
            state_d     = ST_RST_WR;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end

      ST_AP_PRE: begin
        if (ack) begin
          issue = 1'b1;
          if (win_now) begin
            rej_d    = 1'b1;
            pend_clr = 1'b1;
            state_d  = ST_BASE;
          end else begin
            issue_we    = 1'b1;
            issue_addr  = pad_q;
            issue_wdata = ERS_WORD;
            state_d     = ST_AP_WR;
          end
        end
      end

      ST_AP_WR: begin
        if (ack) begin
          pend_clr = 1'b1;
          issue    = 1'b1;
          state_d  = ST_AP_POST;
        end
      end

      ST_AP_POST: begin
        if (ack) begin
          rej_d   = win_now;
          issue   = 1'b1;
          state_d = ST_BASE;
        end
      end

      ST_RST_WR: begin
        if (ack) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  // Append request capture
  always_comb begin
    pend_d = pend_q;
    pad_d  = pad_q;
    if (append_i && !pend_q && op_busy && erase_q) begin
      pend_d = 1'b1;
      pad_d  = append_addr_i;
    end
    if (pend_clr) begin
      pend_d = 1'b0;
    end
  end

  assign opad_en = (state_q == ST_IDLE) & start_i;
  assign pad_en  = append_i & ~pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      code_q  <= FC_NONE;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      code_q  <= code_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
      rej_q   <= rej_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      erase_q <= 1'b0;
      opad_q  <= '0;
    end else if (opad_en) begin
      erase_q <= erase_d;
      opad_q  <= opad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= '0;
    end else if (pad_en) begin
      pad_q <= pad_d;
    end
  end

  assign done_o       = done_q;
  assign fail_o       = fail_q;
  assign fail_code_o  = code_q;
  assign append_rej_o = rej_q;

endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
  parameter int         AW        = 20,
  parameter int         DW        = 8,
  parameter logic [7:0] RESET_CMD = 8'hF0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_ack_i,
  input logic          done_o,
  input logic          fail_o,
  input logic [1:0]    fail_code_o,
  input logic          append_rej_o
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
                                   $stable(bus_addr_o) && $stable(bus_wdata_o)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  fail_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |=> !fail_o);

  // R8
  rej_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    append_rej_o |=> !append_rej_o);

  // R8
  end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  // R8
  end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || fail_o) |-> !bus_req_o);

  // R3
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> (fail_code_o != 2'd0));

  // R4
  reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> $past(bus_req_o && bus_we_o && bus_ack_i &&
                            bus_wdata_o == DW'(RESET_CMD)));

endmodule

bind flash_poll_ctrl fpc_chk #(.AW(AW), .DW(DW), .RESET_CMD(RESET_CMD)) u_fpc_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_req_o    (bus_req_o),
  .bus_we_o     (bus_we_o),
  .bus_addr_o   (bus_addr_o),
  .bus_wdata_o  (bus_wdata_o),
  .bus_ack_i    (bus_ack_i),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .fail_code_o  (fail_code_o),
  .append_rej_o (append_rej_o)
);

// File: tb/flash_poll_ctrl_test.sv
`timescale 1ns/1ps
module flash_poll_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW   = 20;
  localparam int DW   = 8;
  localparam int MAXP = 16;

  logic          clk, rst_n;
  logic          start_i, erase_i, append_i;
  logic [AW-1:0] op_addr_i, append_addr_i;
  logic          bus_req_o, bus_we_o, bus_ack_i;
  logic [AW-1:0] bus_addr_o;
  logic [DW-1:0] bus_wdata_o, bus_rdata_i;
  logic          done_o, fail_o, append_rej_o;
  logic [1:0]    fail_code_o;

  flash_poll_ctrl #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .erase_i(erase_i),
    .op_addr_i(op_addr_i), .append_i(append_i), .append_addr_i(append_addr_i),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
    .done_o(done_o), .fail_o(fail_o), .fail_code_o(fail_code_o),
    .append_rej_o(append_rej_o)
  );

  int errors = 0, checks = 0, cycles = 0;

  // Device model state
  int reads_n, resets_n, erases_n, busy_left, fail_at;
  bit tog, dq3, close_on_ap;
  logic [AW-1:0] last_ap_addr, last_rst_addr;
  int lat;

  // Monitor counts
  int done_n, fail_n, rej_n;
  logic [1:0] last_code;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // Bus slave and flash status model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack_i   <= 1'b0;
      bus_rdata_i <= '0;
      lat = 0;
    end else if (bus_ack_i) begin
      bus_ack_i <= 1'b0;
      lat = $urandom % 3;
    end else if (bus_req_o) begin
      if (lat == 0) begin
        bus_ack_i <= 1'b1;
        if (!bus_we_o) begin
          reads_n = reads_n + 1;
          bus_rdata_i <= {1'b0, tog, (fail_at != 0 && reads_n >= fail_at),
                          1'b0, dq3, 3'b000};
          if (busy_left > 0) begin
            tog = ~tog;
            busy_left = busy_left - 1;
          end
        end else if (bus_wdata_o == 8'hF0) begin
          resets_n = resets_n + 1;
          last_rst_addr = bus_addr_o;
          fail_at = 0;
          busy_left = 0;
        end else if (bus_wdata_o == 8'h30) begin
          erases_n = erases_n + 1;
          last_ap_addr = bus_addr_o;
          if (close_on_ap) dq3 = 1'b1;
        end
      end else begin
        lat = lat - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) done_n++;
      if (fail_o) begin
        fail_n++;
        last_code = fail_code_o;
      end
      if (append_rej_o) rej_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int d0, f0, r0;
  logic [AW-1:0] cur_addr, ap_addr;

  // Run one operation; optional append at cycle 4 and extra start at cycle 6
  task automatic run_op(input bit erase, input int busy, input int fat,
                        input bit dq3_i, input bit close_i,
                        input bit do_ap, input bit do_restart);
    int n;
    @(negedge clk);
    reads_n = 0; resets_n = 0; erases_n = 0;
    busy_left = busy; fail_at = fat; dq3 = dq3_i; close_on_ap = close_i;
    d0 = done_n; f0 = fail_n; r0 = rej_n;
    cur_addr = AW'($urandom);
    ap_addr  = AW'($urandom);
    start_i = 1'b1; erase_i = erase; op_addr_i = cur_addr;
    @(negedge clk);
    start_i = 1'b0; erase_i = 1'b0;
    n = 0;
    while (done_n == d0 && fail_n == f0 && n < 3000) begin
      if (n == 4 && do_ap) begin
        append_i = 1'b1; append_addr_i = ap_addr;
      end else begin
        append_i = 1'b0;
      end
      if (n == 6 && do_restart) begin
        start_i = 1'b1; erase_i = 1'b1; op_addr_i = ~cur_addr;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    append_i = 1'b0; start_i = 1'b0;
    check(n < 3000, "R1 operation ended", n, 3000);
    @(negedge clk);
    @(negedge clk);
    check(bus_req_o == 1'b0, "R8 idle after end", int'(bus_req_o), 0);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; erase_i = 1'b0; append_i = 1'b0;
    op_addr_i = '0; append_addr_i = '0;
    reads_n = 0; resets_n = 0; erases_n = 0; busy_left = 0; fail_at = 0;
    tog = 1'b0; dq3 = 1'b0; close_on_ap = 1'b0;
    done_n = 0; fail_n = 0; rej_n = 0; last_code = 2'd0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check(bus_req_o == 0 && done_o == 0 && fail_o == 0 && append_rej_o == 0 &&
          fail_code_o == 0, "R11 reset outputs",
          int'({bus_req_o, done_o, fail_o, append_rej_o, fail_code_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 plain program
    run_op(0, 5, 0, 0, 0, 0, 0);
    check(done_n == d0 + 1 && fail_n == f0, "R1 done pulse", done_n - d0, 1);
    check(reads_n == 7, "R1 read count busy=5", reads_n, 7);
    check(resets_n == 0, "R4 no reset on success", resets_n, 0);
    check(fail_code_o == 0, "R3 code after success", int'(fail_code_o), 0);

    // R1 boundary: already complete
    run_op(0, 0, 0, 0, 0, 0, 0);
    check(reads_n == 2 && done_n == d0 + 1, "R1 busy=0 reads", reads_n, 2);

    // R5 last read equal still completes
    run_op(0, MAXP - 2, 0, 0, 0, 0, 0);
    check(done_n == d0 + 1 && reads_n == MAXP, "R5 done at limit", reads_n, MAXP);

    // R5 timeout
    run_op(0, MAXP - 1, 0, 0, 0, 0, 0);
    check(fail_n == f0 + 1 && done_n == d0, "R5 timeout fail", fail_n - f0, 1);
    check(last_code == 2'd2, "R3 timeout code", int'(last_code), 2);
    check(reads_n == MAXP, "R5 timeout reads", reads_n, MAXP);
    check(resets_n == 1 && last_rst_addr == cur_addr, "R4 reset write on timeout", resets_n, 1);
    check(fail_code_o == 2'd2, "R3 code held", int'(fail_code_o), 2);

    // R2 device error with continued toggling
    run_op(0, 1000, 4, 0, 0, 0, 0);
    check(fail_n == f0 + 1 && last_code == 2'd1, "R2 device fail code", int'(last_code), 1);
    check(reads_n == 6, "R2 confirm reads", reads_n, 6);
    check(resets_n == 1, "R4 reset write on device fail", resets_n, 1);

    // R2 error flag but completion on the same read
    run_op(0, 4, 5, 0, 0, 0, 0);
    check(done_n == d0 + 1 && fail_n == f0, "R2 completion wins", done_n - d0, 1);
    check(reads_n == 7, "R2 completion reads", reads_n, 7);
    check(fail_code_o == 2'd0, "R3 code cleared by start", int'(fail_code_o), 0);

    // R6 append accepted
    run_op(1, 8, 0, 0, 0, 1, 0);
    check(erases_n == 1 && last_ap_addr == ap_addr, "R6 append write", erases_n, 1);
    check(rej_n == r0 && done_n == d0 + 1, "R6 no reject", rej_n - r0, 0);

    // R6 window closed before append
    run_op(1, 8, 0, 1, 0, 1, 0);
    check(erases_n == 0, "R6 no write when window closed", erases_n, 0);
    check(rej_n == r0 + 1, "R6 reject pulse", rej_n - r0, 1);

    // R7 window closes after append
    run_op(1, 8, 0, 0, 1, 1, 0);
    check(erases_n == 1, "R7 append write issued", erases_n, 1);
    check(rej_n == r0 + 1, "R7 post-check reject", rej_n - r0, 1);

    // R10 append ignored during program
    run_op(0, 8, 0, 0, 0, 1, 0);
    check(erases_n == 0 && rej_n == r0, "R10 append ignored", erases_n, 0);
    check(reads_n == 10, "R10 reads unchanged by append", reads_n, 10);

    // R10 start ignored while busy
    run_op(0, 8, 0, 0, 0, 0, 1);
    check(reads_n == 10 && done_n == d0 + 1, "R10 restart ignored", reads_n, 10);
    check(erases_n == 0 && resets_n == 0, "R10 restart no writes", erases_n + resets_n, 0);

    // Random mix of completions and device errors
    for (int i = 0; i < 24; i++) begin
      int b, f;
      if ($urandom % 3 == 0) begin
        f = 2 + int'($urandom % 9);
        run_op(0, 1000, f, 0, 0, 0, 0);
        check(fail_n == f0 + 1 && last_code == 2'd1, "R2 random device fail", int'(last_code), 1);
        check(reads_n == f + 2 && resets_n == 1, "R4 random fail reads", reads_n, f + 2);
      end else begin
        b = int'($urandom % (MAXP - 1));
        run_op(0, b, 0, 0, 0, 0, 0);
        check(done_n == d0 + 1 && fail_n == f0, "R1 random done", done_n - d0, 1);
        check(reads_n == b + 2, "R1 random reads", reads_n, b + 2);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule